// File: doc/BRIEF.md
# Timer-Paced Parallel Pin Port

This block repurposes a group of eight serial-port pins as a general-purpose 8-bit parallel port. Bytes arrive on a valid/ready stream, wait in a small queue, and are driven onto the pins one at a time. A programmable divider paces the writes. A per-bit direction mask chooses which pins the block drives and which it only reads. Pin samples leave on a second valid/ready stream.

There are two sampling disciplines. In free-running mode the pins are sampled on every timer tick, whether or not a byte is being written. A sample that finds the result slot still occupied is discarded and counted. In lock-step mode a sample is taken only when a byte is written, and it is taken from the pin state just before that byte appears. Each written byte therefore returns exactly one result byte, which shows how the outside world reacted to the previous output. Two active-low strobes, one for writes and one for samples, let external logic clock itself from port accesses.

Top module: `pinport_top`

## Requirements
- R1: After reset, `pin_out` and `pin_oe` are zero, both strobes are high, `out_valid` is low, `drop_count` is zero and `in_ready` is high.
- R2: `pin_oe` follows `dir_mask` bit for bit, one cycle later. A 1 in `dir_mask` makes the pin an output.
- R3: The timer ticks once every L+1 cycles, where L is `rate_div`, or 1 when `rate_div` is 0. Each tick that finds a queued byte drives one byte, in arrival order.
- R4: `wr_n` is low for exactly one cycle per driven byte. That cycle is the first one in which the new byte is on `pin_out`.
- R5: While the queue is empty, `pin_out` keeps its last value and `wr_n` stays high.
- R6: In lock-step mode (`mode_sync`=1), each driven byte yields exactly one result byte. For output-direction bits, the result holds the byte driven before it. For input-direction bits, it holds the synchronized pin level. Both are taken in the cycle before the new byte appears.
- R7: In lock-step mode, a write waits while the result slot is full and is not being taken. Results are never lost and `drop_count` does not change. A result held without `out_ready` keeps its value.
- R8: In free-running mode (`mode_sync`=0), every tick takes a sample and pulls `rd_n` low for one cycle. Writes go ahead whether or not the result slot is free.
- R9: In free-running mode, a sample that finds the slot full and not being taken is discarded. `drop_count` then rises by one and saturates at all ones.
- R10: A sample taken in the same cycle that the consumer takes the slot's previous result is kept, not dropped.
- R11: `in_ready` falls when the queue holds DEPTH bytes and rises again once a byte has been driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sync | input | 1 | 1 selects lock-step sampling, 0 selects free-running sampling |
| dir_mask | input | W | Per-pin direction, 1 = output |
| rate_div | input | DIV_W | Tick interval minus one (0 behaves as 1) |
| in_valid | input | 1 | Byte to drive is offered |
| in_data | input | W | Byte to drive |
| in_ready | output | 1 | Queue can accept a byte |
| out_valid | output | 1 | Result byte available |
| out_data | output | W | Result byte |
| out_ready | input | 1 | Consumer takes the result byte |
| pin_in | input | W | Pin levels seen from outside |
| pin_out | output | W | Driven pin levels |
| pin_oe | output | W | Pin output enables |
| wr_n | output | 1 | Active-low write strobe |
| rd_n | output | 1 | Active-low sample strobe |
| drop_count | output | CNT_W | Saturating count of discarded samples |

## Verification
The sharpest overlap is a free-running sample tick landing in the same cycle that the consumer takes the previous result. The bench holds `out_ready` low until the slot is full. It finds the tick phase from an observed `rd_n` pulse and raises `out_ready` only for the cycle that ends on the next tick. It then requires three things: the old result was handed over, a new result sits in the slot, and `drop_count` is unchanged. In lock-step mode, a write tick can coincide with a full slot. Random backpressure provokes this, and the bench judges it by requiring every result byte, in order, with no drops.

// File: rtl/pinport_pkg.sv
package pinport_pkg;
  typedef enum logic {
    PP_FREE = 1'b0,
    PP_LOCK = 1'b1
  } pp_mode_e;
endpackage

// File: rtl/pinport_tick.sv
module pinport_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] rate_div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] lim;

  // a zero divisor is raised to one so strobes always have a high cycle
  assign lim  = (rate_div == '0) ? DIV_W'(1) : rate_div;
  assign tick = (cnt_q >= lim);

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + DIV_W'(1);
  end

  // R3: ticks are never adjacent
  a_r3_tick_gap: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/pinport_fifo.sv
module pinport_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp_q, rp_q;

  assign empty   = (wp_q == rp_q);
  assign full    = (wp_q[AW] != rp_q[AW]) && (wp_q[AW-1:0] == rp_q[AW-1:0]);
  assign rd_data = mem[rp_q[AW-1:0]];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wp_q[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      if (wr_en) wp_q <= wp_q + 1'b1;
      if (rd_en) rp_q <= rp_q + 1'b1;
    end
  end

  // R11: the queue never overflows or underflows
  a_r11_no_overflow: assert property (@(posedge clk) disable iff (rst)
    full |-> !wr_en);
  a_r11_no_underflow: assert property (@(posedge clk) disable iff (rst)
    empty |-> !rd_en);
endmodule

// File: rtl/pinport_sync.sv
module pinport_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_sync
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign pin_sync = pin_in;
    end else begin : g_chain
      logic [W-1:0] stg_q [STAGES];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
        end else begin
          stg_q[0] <= pin_in;
          for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
        end
      end
      assign pin_sync = stg_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/pinport_core.sv
module pinport_core
  import pinport_pkg::*;
#(
  parameter int W     = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  pp_mode_e         mode,
  input  logic [W-1:0]     dir_mask,
  input  logic             tick,
  input  logic             q_empty,
  input  logic [W-1:0]     q_data,
  output logic             q_pop,
  input  logic [W-1:0]     pin_sync,
  output logic [W-1:0]     pin_out,
  output logic [W-1:0]     pin_oe,
  output logic             wr_n,
  output logic             rd_n,
  output logic             out_valid,
  output logic [W-1:0]     out_data,
  input  logic             out_ready,
  output logic [CNT_W-1:0] drop_count
);
  logic [W-1:0]     drv_q, oe_q, res_q;
  logic             wr_n_q, rd_n_q, res_v_q;
  logic [CNT_W-1:0] drop_q;

  logic             slot_free, do_write, do_sample, do_load, do_drop;
  logic [W-1:0]     readback;

  assign slot_free = !res_v_q || out_ready;
  assign readback  = (drv_q & dir_mask) | (pin_sync & ~dir_mask);
  assign do_write  = tick && !q_empty && ((mode == PP_FREE) || slot_free);
  assign do_sample = tick && ((mode == PP_FREE) || do_write);
  assign do_load   = do_sample && slot_free;
  assign do_drop   = do_sample && !slot_free;
  assign q_pop     = do_write;

  always_ff @(posedge clk) begin
    if (rst) begin
      drv_q  <= '0;
      oe_q   <= '0;
      wr_n_q <= 1'b1;
      rd_n_q <= 1'b1;
    end else begin
      oe_q   <= dir_mask;
      wr_n_q <= !do_write;
      rd_n_q <= !do_sample;
      if (do_write) drv_q <= q_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_v_q <= 1'b0;
      res_q   <= '0;
    end else if (do_load) begin
      res_v_q <= 1'b1;
      res_q   <= readback;
    end else if (out_ready) begin
      res_v_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                                      drop_q <= '0;
    else if (do_drop && (drop_q != {CNT_W{1'b1}})) drop_q <= drop_q + 1'b1;
  end

  assign pin_out    = drv_q;
  assign pin_oe     = oe_q;
  assign wr_n       = wr_n_q;
  assign rd_n       = rd_n_q;
  assign out_valid  = res_v_q;
  assign out_data   = res_q;
  assign drop_count = drop_q;

  // R4: the write strobe lasts one cycle
  a_r4_wr_single: assert property (@(posedge clk) disable iff (rst)
    !wr_n_q |=> wr_n_q);
  // R5: without a write strobe the pins hold
  a_r5_hold_quiet: assert property (@(posedge clk) disable iff (rst)
    wr_n_q |-> $stable(drv_q));
  // R6: in lock-step mode every sample pairs with a write
  a_r6_pair: assert property (@(posedge clk) disable iff (rst)
    (!rd_n_q && $past(mode == PP_LOCK)) |-> !wr_n_q);
  // R7: lock-step mode never drops; a held result stays put
  a_r7_no_drop: assert property (@(posedge clk) disable iff (rst)
    (mode == PP_LOCK) |=> $stable(drop_q));
  a_r7_hold_result: assert property (@(posedge clk) disable iff (rst)
    (res_v_q && !out_ready) |=> (res_v_q && $stable(res_q)));
  // R8: free-running mode samples on each tick
  a_r8_free_sample: assert property (@(posedge clk) disable iff (rst)
    (tick && mode == PP_FREE) |=> !rd_n_q);
  // R9: the drop counter moves by one step at most
  a_r9_drop_step: assert property (@(posedge clk) disable iff (rst)
    (drop_q != $past(drop_q)) |-> (drop_q == $past(drop_q) + 1'b1));
endmodule

// File: rtl/pinport_top.sv
module pinport_top
  import pinport_pkg::*;
#(
  parameter int W           = 8,
  parameter int DIV_W       = 16,
  parameter int DEPTH       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_sync,
  input  logic [W-1:0]     dir_mask,
  input  logic [DIV_W-1:0] rate_div,
  input  logic             in_valid,
  input  logic [W-1:0]     in_data,
  output logic             in_ready,
  output logic             out_valid,
  output logic [W-1:0]     out_data,
  input  logic             out_ready,
  input  logic [W-1:0]     pin_in,
  output logic [W-1:0]     pin_out,
  output logic [W-1:0]     pin_oe,
  output logic             wr_n,
  output logic             rd_n,
  output logic [CNT_W-1:0] drop_count
);
  logic         tick, q_empty, q_full, q_pop;
  logic [W-1:0] q_data, pin_sync;

  assign in_ready = !q_full;

  pinport_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst(rst), .rate_div(rate_div), .tick(tick)
  );

  pinport_fifo #(.W(W), .DEPTH(DEPTH)) u_queue (
    .clk(clk), .rst(rst),
    .wr_en(in_valid && !q_full), .wr_data(in_data),
    .rd_en(q_pop), .rd_data(q_data),
    .empty(q_empty), .full(q_full)
  );

  pinport_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin_in(pin_in), .pin_sync(pin_sync)
  );

  pinport_core #(.W(W), .CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst),
    .mode(pp_mode_e'(mode_sync)), .dir_mask(dir_mask), .tick(tick),
    .q_empty(q_empty), .q_data(q_data), .q_pop(q_pop),
    .pin_sync(pin_sync), .pin_out(pin_out), .pin_oe(pin_oe),
    .wr_n(wr_n), .rd_n(rd_n),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .drop_count(drop_count)
  );
endmodule

// File: tb/sim_pinport_top.sv
module sim_pinport_top;
  localparam int W = 8, DIV_W = 16, DEPTH = 16, CNT_W = 4;

  logic             clk = 1'b0, rst = 1'b1;
  logic             mode_sync = 1'b1, in_valid = 1'b0, out_ready = 1'b1;
  logic [W-1:0]     dir_mask = '0, in_data = '0, pin_in = '0;
  logic [DIV_W-1:0] rate_div = 16'd4;
  logic             in_ready, out_valid, wr_n, rd_n;
  logic [W-1:0]     out_data, pin_out, pin_oe;
  logic [CNT_W-1:0] drop_count;

  pinport_top #(.W(W), .DIV_W(DIV_W), .DEPTH(DEPTH), .SYNC_STAGES(2), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst(rst), .mode_sync(mode_sync), .dir_mask(dir_mask), .rate_div(rate_div),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .wr_n(wr_n), .rd_n(rd_n), .drop_count(drop_count)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, rd_cnt = 0, wr_long = 0;
  bit wr_prev_low = 1'b0, done = 1'b0;
  logic [W-1:0] wr_log[$], resp[$], sent[$], expv[$];
  int wr_cyc[$];

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (!wr_n) begin
        wr_log.push_back(pin_out);
        wr_cyc.push_back(cyc);
        if (wr_prev_low) wr_long++;
      end
      wr_prev_low = !wr_n;
      if (!rd_n) rd_cnt++;
      if (out_valid && out_ready) resp.push_back(out_data);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] model_rb(input logic [W-1:0] drv, input logic [W-1:0] pins,
                                            input logic [W-1:0] dir);
    return (drv & dir) | (pins & ~dir);
  endfunction

  task automatic push(input logic [W-1:0] b);
    @(posedge clk); #1; in_valid = 1'b1; in_data = b;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1; in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_resp(input int n);
    for (int t = 0; t < 3000 && resp.size() < n; t++) @(negedge clk);
  endtask

  task automatic clear_logs();
    wr_log.delete(); wr_cyc.delete(); resp.delete(); sent.delete(); expv.delete();
  endtask

  task automatic compare_run(input string req_w, input string req_r);
    chk(wr_log.size() == sent.size(), req_w, wr_log.size(), sent.size());
    chk(resp.size() == expv.size(), req_r, resp.size(), expv.size());
    for (int i = 0; i < sent.size() && i < wr_log.size(); i++)
      chk(wr_log[i] == sent[i], req_w, wr_log[i], sent[i]);
    for (int i = 0; i < expv.size() && i < resp.size(); i++)
      chk(resp[i] == expv[i], req_r, resp[i], expv[i]);
  endtask

  initial begin
    logic [W-1:0] prev, b, held;
    int n, d0, rd0;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk); #1; rst = 1'b0;
    idle(2);
    // R1 reset state
    chk(pin_out == 0 && pin_oe == 0, "R1", {pin_out, pin_oe}, 0);
    chk(wr_n && rd_n && !out_valid && in_ready && drop_count == 0, "R1",
        {wr_n, rd_n, out_valid, in_ready}, 4'b1101);

    // R2 direction mask
    @(posedge clk); #1; dir_mask = 8'hF0; idle(2);
    chk(pin_oe == 8'hF0, "R2", pin_oe, 8'hF0);
    @(posedge clk); #1; dir_mask = 8'h0F; pin_in = 8'hA5; idle(4);
    chk(pin_oe == 8'h0F, "R2", pin_oe, 8'h0F);

    // R3/R6 lock-step run, free consumer
    clear_logs(); prev = pin_out;
    for (int i = 0; i < 20; i++) begin
      b = W'($urandom);
      sent.push_back(b);
      expv.push_back(model_rb(prev, pin_in, dir_mask));
      prev = b;
      push(b);
    end
    wait_resp(20); idle(5);
    compare_run("R3", "R6");
    for (int i = 1; i < wr_cyc.size(); i++)
      chk(wr_cyc[i] - wr_cyc[i-1] == 5, "R3", wr_cyc[i] - wr_cyc[i-1], 5);

    // R5 empty queue holds
    n = wr_log.size(); held = pin_out; idle(40);
    chk(wr_log.size() == n, "R5", wr_log.size(), n);
    chk(pin_out == held, "R5", pin_out, held);

    // R7 lock-step backpressure
    clear_logs(); prev = pin_out;
    @(posedge clk); #1; out_ready = 1'b0;
    for (int i = 0; i < 3; i++) begin
      b = 8'hC0 + W'(i);
      sent.push_back(b);
      expv.push_back(model_rb(prev, pin_in, dir_mask));
      prev = b;
      push(b);
    end
    idle(40);
    chk(wr_log.size() == 1, "R7", wr_log.size(), 1);
    chk(out_valid && resp.size() == 0, "R7", resp.size(), 0);
    @(posedge clk); #1; out_ready = 1'b1;
    wait_resp(3); idle(5);
    compare_run("R7", "R7");
    chk(drop_count == 0, "R7", drop_count, 0);

    // R6/R7 lock-step with random backpressure
    @(posedge clk); #1; rate_div = 16'd2; pin_in = 8'h3C; idle(6);
    clear_logs(); prev = pin_out;
    for (int i = 0; i < 24; i++) begin
      b = W'($urandom);
      sent.push_back(b);
      expv.push_back(model_rb(prev, 8'h3C, dir_mask));
      prev = b;
    end
    fork
      begin
        for (int i = 0; i < 24; i++) push(sent[i]);
      end
      begin
        repeat (250) begin @(posedge clk); #1; out_ready = 1'($urandom); end
        out_ready = 1'b1;
      end
    join
    wait_resp(24); idle(5);
    compare_run("R6", "R7");
    chk(drop_count == 0, "R7", drop_count, 0);

    // R3 zero divisor gives a two-cycle interval
    @(posedge clk); #1; rate_div = 16'hFFFF; idle(3);
    clear_logs();
    for (int i = 0; i < 6; i++) begin b = W'($urandom); sent.push_back(b); push(b); end
    @(posedge clk); #1; rate_div = 16'd0;
    idle(30);
    chk(wr_log.size() == 6, "R3", wr_log.size(), 6);
    for (int i = 0; i < 6 && i < wr_log.size(); i++) chk(wr_log[i] == sent[i], "R3", wr_log[i], sent[i]);
    for (int i = 1; i < wr_cyc.size(); i++)
      chk(wr_cyc[i] - wr_cyc[i-1] == 2, "R3", wr_cyc[i] - wr_cyc[i-1], 2);

    // R8/R9 free-running mode, stalled consumer
    @(posedge clk); #1; mode_sync = 1'b0; rate_div = 16'd3; pin_in = 8'h5A; idle(8);
    @(negedge clk); while (rd_n) @(negedge clk);
    @(posedge clk); #1; out_ready = 1'b0;
    @(negedge clk);
    resp.delete(); rd0 = rd_cnt; d0 = drop_count;
    idle(41);
    n = rd_cnt - rd0;
    chk(n >= 10 && n <= 11, "R8", n, 10);
    chk(drop_count == d0 + n - 1, "R9", drop_count, d0 + n - 1);
    chk(out_valid && resp.size() == 0, "R9", resp.size(), 0);
    chk(out_data == model_rb(pin_out, 8'h5A, dir_mask), "R9", out_data, model_rb(pin_out, 8'h5A, dir_mask));

    // R10 take the result in the cycle that a tick lands
    @(negedge clk); while (rd_n) @(negedge clk);
    d0 = drop_count; held = out_data;
    repeat (3) @(posedge clk);
    #1; out_ready = 1'b1;
    @(posedge clk); #1; out_ready = 1'b0;
    @(negedge clk);
    chk(!rd_n, "R10", rd_n, 0);
    chk(drop_count == d0, "R10", drop_count, d0);
    chk(resp.size() == 1 && resp[0] == held, "R10", resp.size(), 1);
    chk(out_valid, "R10", out_valid, 1);

    // R8 writes proceed with a full slot; R9 saturation
    clear_logs();
    push(8'h11); push(8'h22);
    idle(20);
    chk(wr_log.size() == 2 && wr_log[0] == 8'h11, "R8", wr_log.size(), 2);
    idle(80);
    chk(drop_count == 4'hF, "R9", drop_count, 4'hF);

    // R11 queue full
    @(posedge clk); #1; out_ready = 1'b1; rate_div = 16'hFFFF; idle(3);
    clear_logs();
    for (int i = 0; i < DEPTH; i++) begin b = W'($urandom); sent.push_back(b); push(b); end
    @(negedge clk);
    chk(!in_ready, "R11", in_ready, 0);
    @(posedge clk); #1; rate_div = 16'd0;
    idle(60);
    chk(in_ready, "R11", in_ready, 1);
    chk(wr_log.size() == DEPTH, "R11", wr_log.size(), DEPTH);
    for (int i = 0; i < DEPTH && i < wr_log.size(); i++) chk(wr_log[i] == sent[i], "R11", wr_log[i], sent[i]);

    // R4 write strobe never wider than one cycle
    chk(wr_long == 0, "R4", wr_long, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule